// File: doc/BRIEF.md
# Serial Flash Identification Command Responder

This block is the serial-interface front end of a flash memory model. It watches a four-wire SPI bus in mode 0 (data sampled on the rising clock edge, shifted out on the falling edge). It decodes the command byte that opens every chip-select frame and answers the identification commands on the data-out line. It also tracks the write-enable latch and the deep power-down state.

The serial lines are oversampled by a fast system clock through a synchronizer. Every decision is therefore made in a single clock domain with synchronous reset. The array, program and erase engines and status reads are not here. The block only exports the latch-derived permit, which a write-class command needs before it can be accepted.

Top module: `spi_id_responder`

## Requirements
- R1: After reset, `wel`, `deep_pd`, `write_permit` and `miso_oe` are all 0.
- R2: All bytes travel most significant bit first. `miso_oe` is 1 only while reply data is being shifted out, and it is 0 during the command, dummy and selector bytes.
- R3: Command ABh clears `deep_pd`. After three further dummy bytes it returns the device byte 14h repeatedly until chip select rises.
- R4: Command 90h is followed by two dummy bytes and a selector byte. A selector with bit 0 = 0 (for example 00h) gives the stream 1Ch, 14h, 1Ch, 14h, and so on.
- R5: For command 90h, a selector with bit 0 = 1 (for example 01h) gives the stream 14h, 1Ch, 14h, 1Ch, and so on.
- R6: Command 9Fh returns 1Ch, then 30h, then 15h, then 00h for every byte after that.
- R7: Command 06h sets `wel` when chip select rises exactly after the eighth command bit.
- R8: If chip select rises partway through the 06h byte, or after bits beyond the 06h byte, `wel` keeps its previous value.
- R9: Command B9h, closed on a byte boundary, sets `deep_pd`. While `deep_pd` is 1, every command other than ABh is ignored: there is no reply, `wel` does not change and `write_permit` stays 0.
- R10: After a write-class command byte (02h, 20h, D8h, C7h, 01h), `write_permit` equals `wel`. It holds that value for the rest of the frame and returns to 0 when chip select rises.
- R11: A rise of chip select at any point ends the current command. `miso_oe` drops, and the next frame is decoded from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the bus master |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial reply data |
| miso_oe | output | 1 | Drive enable for `miso` (1 = drive) |
| wel | output | 1 | Write-enable latch |
| deep_pd | output | 1 | Deep power-down state |
| write_permit | output | 1 | Permit for the current write-class command |

## Verification
The bench uses the default parameters: a two-stage synchronizer and identity bytes 1Ch, 14h and 3015h. The serial clock runs with eight system clocks per half period. That gives the synchronizer and decoder enough margin to place every reply bit before the master's next rising edge, so each stream can be read for four or more bytes. The default dummy counts (three for ABh, two for 90h) reach the selector byte and the endless-repeat tail of both ID streams. With the two-bit stream index, the 9Fh sequence runs past its saturation point into the 00h filler.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;

  typedef enum logic [2:0] {
    ST_OPC, ST_DUMMY, ST_SEL, ST_STREAM,
    ST_HOLD_WREN, ST_HOLD_PD, ST_WRCMD, ST_SINK
  } dec_state_t;

  typedef enum logic [1:0] {RP_ID, RP_ALT, RP_JEDEC} reply_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RES   = 8'hAB;
  localparam logic [7:0] OP_MFDV  = 8'h90;
  localparam logic [7:0] OP_JEDEC = 8'h9F;
  localparam logic [7:0] OP_DPD   = 8'hB9;

  function automatic logic is_write_op(input logic [7:0] op);
    return (op == 8'h02) || (op == 8'h20) || (op == 8'hD8) ||
           (op == 8'hC7) || (op == 8'h01);
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic cs_hi,
  output logic cs_rise,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);
  logic [STAGES-1:0] cs_p, ck_p, di_p;
  logic cs_q, ck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= '1;
      ck_p <= '0;
      di_p <= '0;
      cs_q <= 1'b1;
      ck_q <= 1'b0;
    end else begin
      cs_p <= {cs_p[STAGES-2:0], cs_n};
      ck_p <= {ck_p[STAGES-2:0], sclk};
      di_p <= {di_p[STAGES-2:0], mosi};
      cs_q <= cs_p[STAGES-1];
      ck_q <= ck_p[STAGES-1];
    end
  end

  assign cs_hi     = cs_p[STAGES-1];
  assign cs_rise   = cs_p[STAGES-1] & ~cs_q;
  assign sclk_rise = ck_p[STAGES-1] & ~ck_q & ~cs_p[STAGES-1];
  assign sclk_fall = ~ck_p[STAGES-1] & ck_q & ~cs_p[STAGES-1];
  assign mosi_s    = di_p[STAGES-1];

  initial if (STAGES < 2) $error("spi_in_sync needs at least two stages");
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx #(
  parameter int W = 8,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_hi,
  input  logic          sclk_rise,
  input  logic          mosi_s,
  output logic          byte_valid,
  output logic [W-1:0]  rx_byte,
  output logic [CW-1:0] bit_cnt
);
  logic [W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
      rx_byte <= '0;
      byte_valid <= 1'b0;
      bit_cnt <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (cs_hi) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        sh <= {sh[W-3:0], mosi_s};
        if (bit_cnt == CW'(W-1)) begin
          rx_byte <= {sh, mosi_s};
          byte_valid <= 1'b1;
          bit_cnt <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R11: a deselected bus leaves the bit counter at zero
  assert_cnt_clear_R11: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (bit_cnt == '0));
endmodule

// File: rtl/id_byte_sel.sv
module id_byte_sel
  import spi_id_pkg::*;
#(
  parameter logic [7:0]  MFR_ID   = 8'h1C,
  parameter logic [7:0]  DEV_ID   = 8'h14,
  parameter logic [15:0] JEDEC_ID = 16'h3015
) (
  input  reply_t      kind,
  input  logic        first_dev,
  input  logic [1:0]  idx,
  output logic [7:0]  byte_out
);
  always_comb begin
    unique case (kind)
      RP_ALT:   byte_out = (idx[0] ^ first_dev) ? DEV_ID : MFR_ID;
      RP_JEDEC: begin
        unique case (idx)
          2'd0:    byte_out = MFR_ID;
          2'd1:    byte_out = JEDEC_ID[15:8];
          2'd2:    byte_out = JEDEC_ID[7:0];
          default: byte_out = 8'h00;
        endcase
      end
      default:  byte_out = DEV_ID;
    endcase
  end
endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
  import spi_id_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          RES_DUMMIES = 3,
  parameter int          MD_DUMMIES  = 2,
  parameter logic [7:0]  MFR_ID      = 8'h1C,
  parameter logic [7:0]  DEV_ID      = 8'h14,
  parameter logic [15:0] JEDEC_ID    = 16'h3015
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic miso_oe,
  output logic wel,
  output logic deep_pd,
  output logic write_permit
);
  localparam int BW   = 8;
  localparam int CW   = $clog2(BW);
  localparam int DMAX = (RES_DUMMIES > MD_DUMMIES) ? RES_DUMMIES : MD_DUMMIES;
  localparam int DW   = $clog2(DMAX + 1);

  logic cs_hi, cs_rise, sclk_rise, sclk_fall, mosi_s;
  logic byte_valid;
  logic [BW-1:0] rx_byte, cur_byte;
  logic [CW-1:0] bit_cnt;

  dec_state_t    state;
  reply_t        kind;
  logic          first_dev;
  logic [1:0]    idx;
  logic [DW-1:0] dummy_left;
  logic          wel_r, pd_r, permit_r, miso_r, oe_r;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .cs_hi(cs_hi), .cs_rise(cs_rise), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(mosi_s));

  spi_byte_rx #(.W(BW)) u_rx (
    .clk(clk), .rst(rst), .cs_hi(cs_hi), .sclk_rise(sclk_rise),
    .mosi_s(mosi_s), .byte_valid(byte_valid), .rx_byte(rx_byte),
    .bit_cnt(bit_cnt));

  id_byte_sel #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .JEDEC_ID(JEDEC_ID)) u_sel (
    .kind(kind), .first_dev(first_dev), .idx(idx), .byte_out(cur_byte));

  // command decoder and latches
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OPC;
      kind       <= RP_ID;
      first_dev  <= 1'b0;
      idx        <= '0;
      dummy_left <= '0;
      wel_r      <= 1'b0;
      pd_r       <= 1'b0;
      permit_r   <= 1'b0;
    end else if (cs_hi) begin
      state    <= ST_OPC;
      permit_r <= 1'b0;
      if (cs_rise && bit_cnt == '0) begin
        if (state == ST_HOLD_WREN) wel_r <= 1'b1;
        if (state == ST_HOLD_PD)   pd_r  <= 1'b1;
      end
    end else if (byte_valid) begin
      unique case (state)
        ST_OPC: begin
          idx <= '0;
          if (pd_r && rx_byte != OP_RES) begin
            state <= ST_SINK;
          end else if (rx_byte == OP_RES) begin
            pd_r       <= 1'b0;
            kind       <= RP_ID;
            dummy_left <= DW'(RES_DUMMIES);
            state      <= ST_DUMMY;
          end else if (rx_byte == OP_MFDV) begin
            kind       <= RP_ALT;
            dummy_left <= DW'(MD_DUMMIES);
            state      <= ST_DUMMY;
          end else if (rx_byte == OP_JEDEC) begin
            kind  <= RP_JEDEC;
            state <= ST_STREAM;
          end else if (rx_byte == OP_WREN) begin
            state <= ST_HOLD_WREN;
          end else if (rx_byte == OP_DPD) begin
            state <= ST_HOLD_PD;
          end else if (is_write_op(rx_byte)) begin
            permit_r <= wel_r;
            state    <= ST_WRCMD;
          end else begin
            state <= ST_SINK;
          end
        end
        ST_DUMMY: begin
          dummy_left <= dummy_left - 1'b1;
          if (dummy_left == DW'(1))
            state <= (kind == RP_ALT) ? ST_SEL : ST_STREAM;
        end
        ST_SEL: begin
          first_dev <= rx_byte[0];
          state     <= ST_STREAM;
        end
        ST_STREAM: begin
          if (!(kind == RP_JEDEC && idx == 2'd3)) idx <= idx + 1'b1;
        end
        ST_HOLD_WREN, ST_HOLD_PD: state <= ST_SINK;
        default: ;
      endcase
    end
  end

  // reply shifter: new bit on every falling edge of the serial clock
  always_ff @(posedge clk) begin
    if (rst) begin
      miso_r <= 1'b0;
      oe_r   <= 1'b0;
    end else if (cs_hi) begin
      oe_r <= 1'b0;
    end else if (sclk_fall) begin
      oe_r   <= (state == ST_STREAM);
      miso_r <= (state == ST_STREAM) ? cur_byte[BW-1-int'(bit_cnt)] : 1'b0;
    end
  end

  assign miso         = miso_r;
  assign miso_oe      = oe_r;
  assign wel          = wel_r;
  assign deep_pd      = pd_r;
  assign write_permit = permit_r;

  assert_oe_stream_R2: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> (state == ST_STREAM));
  assert_oe_drop_R11: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> !miso_oe);
  assert_wel_on_close_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(cs_rise) && !$past(pd_r));
  assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    deep_pd |-> (state inside {ST_OPC, ST_SINK, ST_HOLD_PD}));
  assert_permit_gated_R10: assert property (@(posedge clk) disable iff (rst)
    write_permit |-> (wel && !deep_pd));
endmodule

// File: tb/tb_spi_id_responder.sv
module tb_spi_id_responder;
  localparam int H = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, wel, deep_pd, write_permit;
  int total = 0, bad = 0, cycles = 0;
  bit m_wel = 0, m_pd = 0;

  always #2 clk = ~clk;

  spi_id_responder dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wel(wel), .deep_pd(deep_pd),
    .write_permit(write_permit));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int kind, input bit fd, input int i);
    if (kind == 0) return 8'h14;
    if (kind == 1) return ((i % 2 == 1) ^ fd) ? 8'h14 : 8'h1C;
    case (i)
      0: return 8'h1C;
      1: return 8'h30;
      2: return 8'h15;
      default: return 8'h00;
    endcase
  endfunction

  task automatic xfer(input logic [7:0] tx, input int nbits,
                      output logic [7:0] rx, output bit oe_any, output bit oe_all);
    rx = '0; oe_any = 0; oe_all = 1;
    for (int b = 0; b < nbits; b++) begin
      mosi = tx[7-b];
      repeat (H) @(negedge clk);
      rx[7-b] = miso;
      oe_any |= miso_oe;
      oe_all &= miso_oe;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic sel_lo;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic sel_hi;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // kind: 0 = ABh, 1 = 90h, 2 = 9Fh
  task automatic id_read(input int kind, input logic [7:0] sel, input int nread);
    logic [7:0] rx, op;
    bit a, l;
    bit live = !m_pd || kind == 0;
    int nd = (kind == 0) ? 3 : (kind == 1) ? 2 : 0;
    op = (kind == 0) ? 8'hAB : (kind == 1) ? 8'h90 : 8'h9F;
    sel_lo();
    xfer(op, 8, rx, a, l);
    chk(!a, "R2 oe low during command", a, 0);
    for (int d = 0; d < nd; d++) begin
      xfer(8'h00, 8, rx, a, l);
      chk(!a, "R2 oe low during dummy", a, 0);
    end
    if (kind == 1) begin
      xfer(sel, 8, rx, a, l);
      chk(!a, "R2 oe low during selector", a, 0);
    end
    if (kind == 0) m_pd = 0;
    for (int k = 0; k < nread; k++) begin
      xfer(8'h00, 8, rx, a, l);
      if (live) begin
        chk(l && rx == exp_byte(kind, sel[0], k),
            (kind == 0) ? "R3 id stream" : (kind == 2) ? "R6 jedec stream" :
            sel[0] ? "R5 dev-first stream" : "R4 mfr-first stream",
            {l, rx}, {1'b1, exp_byte(kind, sel[0], k)});
      end else begin
        chk(!a, "R9 no reply in power-down", a, 0);
      end
    end
    sel_hi();
    chk(!miso_oe, "R11 oe off after deselect", miso_oe, 0);
    chk(deep_pd == m_pd, "R3 power-down state", deep_pd, m_pd);
  endtask

  task automatic simple_cmd(input logic [7:0] op, input int extra_bits, input int nbits);
    logic [7:0] rx;
    bit a, l;
    sel_lo();
    xfer(op, nbits, rx, a, l);
    if (extra_bits > 0) xfer(8'hFF, extra_bits, rx, a, l);
    sel_hi();
  endtask

  task automatic do_wren;
    simple_cmd(8'h06, 0, 8);
    if (!m_pd) m_wel = 1;
    chk(wel == m_wel, m_pd ? "R9 wren ignored in power-down" : "R7 wren sets latch", wel, m_wel);
  endtask

  task automatic do_abort_wren(input int mode);
    if (mode == 0) simple_cmd(8'h06, 0, 1 + $urandom % 7);
    else simple_cmd(8'h06, 1 + $urandom % 9, 8);
    chk(wel == m_wel, "R8 aborted wren keeps latch", wel, m_wel);
  endtask

  task automatic do_pd;
    simple_cmd(8'hB9, 0, 8);
    m_pd = 1;
    chk(deep_pd == 1'b1, "R9 enter power-down", deep_pd, 1);
  endtask

  task automatic do_write(input logic [7:0] op);
    logic [7:0] rx;
    bit a, l;
    bit e = m_wel && !m_pd;
    sel_lo();
    xfer(op, 8, rx, a, l);
    repeat (4) @(negedge clk);
    chk(write_permit == e, "R10 permit follows latch", write_permit, e);
    xfer(8'h12, 8, rx, a, l);
    chk(write_permit == e, "R10 permit held in frame", write_permit, e);
    sel_hi();
    chk(!write_permit, "R10 permit cleared on deselect", write_permit, 0);
  endtask

  initial begin
    logic [7:0] wops [5] = '{8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01};
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk({wel, deep_pd, write_permit, miso_oe} == 4'b0, "R1 reset state",
        {wel, deep_pd, write_permit, miso_oe}, 0);

    // directed corner cases
    do_write(8'h02);                 // R10 with latch clear
    id_read(2, 8'h00, 6);            // R6 past the third byte
    id_read(1, 8'h00, 5);            // R4
    id_read(1, 8'h01, 5);            // R5
    id_read(0, 8'h00, 5);            // R3
    do_abort_wren(0);                // R8 mid-byte
    do_abort_wren(1);                // R8 extra bits
    do_wren();                       // R7
    do_write(8'hD8);                 // R10 with latch set
    // R11: abort a reply mid-stream, then a fresh frame decodes
    begin
      logic [7:0] rx; bit a, l;
      sel_lo(); xfer(8'h9F, 8, rx, a, l); xfer(8'h00, 5, rx, a, l); sel_hi();
    end
    id_read(2, 8'h00, 4);            // R11 fresh decode
    do_pd();                         // R9
    id_read(2, 8'h00, 2);            // R9 ignored
    do_write(8'h20);                 // R9 no permit in power-down
    id_read(0, 8'h00, 4);            // R3 wake

    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      case ($urandom % 7)
        0: do_wren();
        1: id_read(2, 8'h00, 3 + $urandom % 3);
        2: id_read(1, {7'h0, 1'($urandom % 2)}, 4 + $urandom % 2);
        3: id_read(0, 8'h00, 4);
        4: do_pd();
        5: do_write(wops[$urandom % 5]);
        default: do_abort_wren($urandom % 2);
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule